// File: doc/BRIEF.md
# Serial-Bus Delay Code Register Target

This block is a target on a two-wire serial bus (I2C). It keeps one 6-bit delay code for each of three channels and presents all of them as parallel outputs, so that neighbouring delay logic can use them directly. A bus controller picks a channel with a register byte and then writes a new code, or reads the stored code back.

The bus lines are sampled by a system clock that runs much faster than SCL. Both lines pass through a two-flop synchroniser, and START and STOP are found from the synchronised levels. The data line is open-drain. The block only asserts `sda_oe` to pull SDA low, and the board's pull-up gives the high level. The 7-bit bus address is a fixed five-bit prefix followed by two strap pins, so up to four of these targets can share one bus.

A write has three bytes: the address with the direction bit clear, the register byte, and the data byte. A read sets the channel with the first two bytes of a write. The controller then sends a repeated START and the address with the direction bit set, and the target returns one byte. The byte-level traffic has no back-pressure: the target never stretches SCL, so every byte completes at the controller's pace. The stored codes are plain level outputs with no handshake.

Top module: `i2c_delay_target`

## Requirements
- R1: After reset, every delay code reads zero and `sda_oe` is 0, so SDA is released.
- R2: The target responds only to the 7-bit address {0,1,1,1,0,strap_i[1],strap_i[0]} (0x38 to 0x3B). The address byte is that address followed by the direction bit, with 0 for write and 1 for read. The target acknowledges a matching address by pulling SDA low during the ninth SCL pulse.
- R3: Consider the sequence START, address+0, register byte, data byte, STOP. Each of the three bytes is acknowledged. The channel named by register bits [1:0] then holds data bits [5:0]. Channel k appears on `delay_codes[6k+5:6k]`.
- R4: Bits 7 and 6 of a write data byte have no effect on the stored code.
- R5: Consider the sequence START, address+0, register byte, repeated START, address+1. The target then sends {2'b00, code} of the selected channel, most significant bit first. The controller answers with NACK and then STOP.
- R6: Channel index 3 is acknowledged. A write to it leaves every code unchanged, and a read from it returns 0x00.
- R7: A byte with a non-matching address is not acknowledged. The target then drives nothing and changes no code until the next START or STOP.
- R8: A START seen at any point, including partway through a byte, restarts address reception.
- R9: `sda_oe` changes level only while SCL is low.
- R10: A write changes at most the one selected channel, and only while SCL is high on the last data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| strap_i | input | 2 | Address straps: [1] is the upper bit, [0] the lower |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| delay_codes | output | 18 | Stored codes, channel k in bits [6k+5:6k] |

## Verification
The assertions assume a well-behaved controller. It changes SDA only while SCL is low, except for its own START and STOP conditions. Each SCL high or low phase lasts several system clocks, longer than the synchroniser and edge-detect latency. `sda_i` is the wired-AND of the controller's drive and `sda_oe`. The bench's bit tasks hold every quarter of an SCL period for eight clocks and derive `sda_i` by that wired-AND, so the target's drive and commit points always land inside the SCL phase the assertions expect.

// File: rtl/i2c_dly_pkg.sv
package i2c_dly_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDAT,
    ST_ACKW,
    ST_ACKD,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  // Stage 1 and 2 synchronise, stage 3 holds the previous level.
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign sda_s    = sda_p[1];
  assign scl_rise = scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] & scl_p[2];
  assign start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/i2c_dly_regs.sv
module i2c_dly_regs #(
  parameter int NCH  = 3,
  parameter int CW   = 6,
  parameter int IDXW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [CW-1:0]     wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [CW-1:0]     rd_data,
  output logic [NCH*CW-1:0] codes
);
  logic [CW-1:0] code_q [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        code_q[k] <= '0;
      else if (wr_en && wr_idx == IDXW'(k))
        code_q[k] <= wr_data;
    end
    assign codes[k*CW +: CW] = code_q[k];
  end

  // Indices without storage read back zero.
  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NCH; k++)
      if (rd_idx == IDXW'(k)) rd_data = code_q[k];
  end
endmodule

// File: rtl/i2c_dly_proto.sv
module i2c_dly_proto
  import i2c_dly_pkg::*;
#(
  parameter int          CW   = 6,
  parameter int          IDXW = 2,
  parameter logic [4:0]  BASE = 5'b01110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_c,
  input  logic            stop_c,
  input  logic [1:0]      strap_i,
  input  logic [CW-1:0]   rd_data,
  output logic            wr_en,
  output logic [IDXW-1:0] ptr,
  output logic [CW-1:0]   wr_data,
  output logic            sda_oe
);
  st_e        st, nxt;
  logic [2:0] cnt;
  logic [6:0] sh;
  logic [7:0] byte_in, rd_byte;
  logic [6:0] dev_addr;

  assign dev_addr = {BASE, strap_i};
  assign byte_in  = {sh, sda_s};
  assign rd_byte  = 8'(rd_data);
  assign wr_data  = sh[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      nxt    <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_REG, ST_WDAT: begin
            if (scl_rise) begin
              sh  <= byte_in[6:0];
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                case (st)
                  ST_ADDR: begin
                    if (byte_in[7:1] == dev_addr) begin
                      st  <= ST_ACKW;
                      nxt <= byte_in[0] ? ST_RDAT : ST_REG;
                    end else begin
                      st <= ST_WAIT;
                    end
                  end
                  ST_REG: begin
                    ptr <= byte_in[IDXW-1:0];
                    st  <= ST_ACKW;
                    nxt <= ST_WDAT;
                  end
                  default: begin
                    wr_en <= 1'b1;
                    st    <= ST_ACKW;
                    nxt   <= ST_WAIT;
                  end
                endcase
              end
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= ST_ACKD;
          end
          ST_ACKD: if (scl_fall) begin
            if (nxt == ST_RDAT) begin
              sh     <= rd_byte[6:0];
              sda_oe <= ~rd_byte[7];
              cnt    <= '0;
            end else begin
              sda_oe <= 1'b0;
            end
            st <= nxt;
          end
          ST_RDAT: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[5:0], 1'b0};
              cnt    <= cnt + 3'd1;
            end
          end
          ST_RACK: if (scl_rise) st <= ST_WAIT;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_delay_target.sv
module i2c_delay_target #(
  parameter int         NCH  = 3,
  parameter int         CW   = 6,
  parameter int         IDXW = 2,
  parameter logic [4:0] BASE = 5'b01110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_oe,
  output logic [NCH*CW-1:0] delay_codes
);
  logic            sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic            wr_en;
  logic [IDXW-1:0] ptr;
  logic [CW-1:0]   wr_data, rd_data;

  i2c_line_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2c_dly_proto #(.CW(CW), .IDXW(IDXW), .BASE(BASE)) u_proto (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .strap_i  (strap_i),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .ptr      (ptr),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  i2c_dly_regs #(.NCH(NCH), .CW(CW), .IDXW(IDXW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (ptr),
    .wr_data (wr_data),
    .rd_idx  (ptr),
    .rd_data (rd_data),
    .codes   (delay_codes)
  );
endmodule

// File: rtl/i2c_delay_target_chk.sv
module i2c_delay_target_chk #(
  parameter int NCH = 3,
  parameter int CW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe,
  input logic [NCH*CW-1:0] delay_codes
);
  logic [NCH*CW-1:0] prev_codes;
  logic [NCH-1:0]    chg;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_codes <= '0;
    else        prev_codes <= delay_codes;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_chg
    assign chg[k] = prev_codes[k*CW +: CW] != delay_codes[k*CW +: CW];
  end

  // R9: drive level moves only in the SCL low phase
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R9: when driving, the line is low (only pulls low)
  a_r9_oe_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_i);

  // R10: at most one channel moves at a time
  a_r10_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  // R10: stored codes move only while SCL is high
  a_r10_commit_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |-> scl_i);
endmodule

bind i2c_delay_target i2c_delay_target_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_oe      (sda_oe),
  .delay_codes (delay_codes)
);

// File: tb/i2c_delay_target_bench.sv
module i2c_delay_target_bench;
  localparam int NCH = 3;
  localparam int CW  = 6;
  localparam int Q   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic sda_oe;
  logic sda_line;
  logic [NCH*CW-1:0] delay_codes;

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  int  exp_code [4];
  bit  pend = 0;
  int  pend_idx = 0;
  int  pend_val = 0;
  bit  run_cmp = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_delay_target u_i2c_delay_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .strap_i     (strap),
    .sda_oe      (sda_oe),
    .delay_codes (delay_codes)
  );

  function automatic logic [NCH*CW-1:0] pack_model(input bit with_pend);
    logic [NCH*CW-1:0] v = '0;
    for (int k = 0; k < NCH; k++) begin
      int c = exp_code[k];
      if (with_pend && pend_idx == k) c = pend_val;
      v[k*CW +: CW] = CW'(c);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R10: per-clock comparison against the model
  always @(negedge clk) begin
    if (run_cmp) begin
      bit ok;
      ok = (delay_codes == pack_model(0)) || (pend && delay_codes == pack_model(1));
      chk(ok, "R10 codes vs model", int'(delay_codes), int'(pack_model(0)));
    end
  end

  task automatic q_wait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait();
    scl = 1'b1;   q_wait();
    sda_m = 1'b0; q_wait();
    scl = 1'b0;   q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait();
    scl = 1'b1;   q_wait();
    sda_m = 1'b1; q_wait();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; q_wait();
    scl = 1'b1; q_wait(); q_wait();
    scl = 1'b0; q_wait();
  endtask

  task automatic recv_bit(output bit b);
    sda_m = 1'b1; q_wait();
    scl = 1'b1;   q_wait();
    b = sda_line; q_wait();
    scl = 1'b0;   q_wait();
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(1'b1);
  endtask

  function automatic bit addr_hit(input logic [6:0] a);
    return a == {5'b01110, strap};
  endfunction

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                        output logic [2:0] acks);
    bit k;
    bus_start();
    wbyte({a, 1'b0}, k); acks[2] = k;
    wbyte(r, k);         acks[1] = k;
    if (addr_hit(a) && r[1:0] != 2'd3) begin
      pend_idx = int'(r[1:0]);
      pend_val = int'(d[5:0]);
      pend = 1;
    end
    wbyte(d, k);         acks[0] = k;
    if (pend) begin
      exp_code[pend_idx] = pend_val;
      pend = 0;
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] r,
                        output logic [7:0] d, output logic [2:0] acks);
    bit k;
    bus_start();
    wbyte({a, 1'b0}, k); acks[2] = k;
    wbyte(r, k);         acks[1] = k;
    bus_start();
    wbyte({a, 1'b1}, k); acks[0] = k;
    rbyte(d);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    bit k;
    for (int i = 0; i < 4; i++) exp_code[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(delay_codes == '0, "R1 codes after reset", int'(delay_codes), 0);
    chk(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
    run_cmp = 1;

    // R2 R3: basic writes, strap 00
    wr_txn(7'h38, 8'h00, 8'h15, acks);
    chk(acks == 3'b111, "R2 R3 write ack ch0", int'(acks), 7);
    wr_txn(7'h38, 8'h01, 8'h2A, acks);
    chk(acks == 3'b111, "R3 write ack ch1", int'(acks), 7);
    // R4: upper data bits ignored
    wr_txn(7'h38, 8'h02, 8'hFC, acks);
    chk(delay_codes[12 +: 6] == 6'h3C, "R4 upper bits ignored", int'(delay_codes[12 +: 6]), 'h3C);
    chk(delay_codes[0 +: 6] == 6'h15, "R3 ch0 code", int'(delay_codes[0 +: 6]), 'h15);

    // R5: reads, MSB first
    rd_txn(7'h38, 8'h00, rd, acks);
    chk(rd == 8'h15 && acks == 3'b111, "R5 read ch0", int'(rd), 'h15);
    rd_txn(7'h38, 8'h01, rd, acks);
    chk(rd == 8'h2A, "R5 read ch1", int'(rd), 'h2A);
    rd_txn(7'h38, 8'h02, rd, acks);
    chk(rd == 8'h3C, "R5 read ch2", int'(rd), 'h3C);
    chk(sda_oe == 1'b0, "R9 released after read", int'(sda_oe), 0);

    // R6: channel 3
    wr_txn(7'h38, 8'h03, 8'h11, acks);
    chk(acks == 3'b111, "R6 ch3 acked", int'(acks), 7);
    chk(delay_codes == pack_model(0), "R6 ch3 write discarded", int'(delay_codes), int'(pack_model(0)));
    rd_txn(7'h38, 8'h03, rd, acks);
    chk(rd == 8'h00, "R6 ch3 reads zero", int'(rd), 0);

    // R2 with other strap, R7 mismatch
    strap = 2'b11;
    repeat (4) @(negedge clk);
    wr_txn(7'h3B, 8'h01, 8'h07, acks);
    chk(acks == 3'b111, "R2 strap 11 acked", int'(acks), 7);
    wr_txn(7'h38, 8'h00, 8'h3F, acks);
    chk(acks == 3'b000, "R7 mismatch no ack", int'(acks), 0);
    chk(delay_codes[0 +: 6] == 6'h15, "R7 code unchanged", int'(delay_codes[0 +: 6]), 'h15);
    rd_txn(7'h3B, 8'h01, rd, acks);
    chk(rd == 8'h07, "R2 R5 read after strap change", int'(rd), 7);

    // R8: START partway through a byte
    bus_start();
    wbyte({7'h3B, 1'b0}, k);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    wr_txn(7'h3B, 8'h02, 8'h01, acks);
    chk(acks == 3'b111, "R8 restart acked", int'(acks), 7);
    chk(delay_codes[12 +: 6] == 6'h01, "R8 write after restart", int'(delay_codes[12 +: 6]), 1);
    chk(sda_oe == 1'b0, "R9 idle released", int'(sda_oe), 0);

    run_cmp = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule